// File: doc/BRIEF.md
# Shared-Pin Microcontroller Bus Address Recovery

This block sits behind the pins of a microcontroller bus on which address and data share the same lines. It runs on a local clock and passes every bus input through a two-stage synchronizer. It detects the falling edge of the address-latch-enable strobe and, at that edge, takes the address off the shared lines. It presents a full 20-bit address that stays steady while the shared lines carry data. It also decodes the program-fetch, read and write strobes into active-high qualifiers. It flags a data phase and reports a protocol error when more than one strobe is asserted at the same time.

A two-bit configuration input selects one of four pin layouts:

- Low-byte multiplexed (code 0): this layout has no read strobe.
- Page multiplexed (code 1): the upper address byte shares the data lines.
- Byte-wide multiplexed (code 2).
- Word-wide multiplexed (code 3).

In the last two layouts the four lowest address bits come from dedicated pins, and the block passes their live value through. This lets a burst of code fetches step through up to 16 consecutive bytes under one latched upper address, with no new latch-enable pulse. The configuration input is taken only while the bus is idle.

Top module: `mab_top`

## Requirements
- R1: After reset, `addr_out` is zero, `rd_q`, `wr_q`, `fetch_q`, `data_phase` and `proto_err` are low, and `mode_q` is 0.
- R2: In mode 0, at the falling edge of `ale_in`, `addr_out[15:8]` is taken from `ad_in[15:8]` and `addr_out[7:0]` from `ad_in[7:0]`, with `addr_out[19:16]` = 0. `addr_out[3:0]` does not follow `a_lo_in`.
- R3: In mode 1 (page), at the falling edge of `ale_in`, `addr_out[15:8]` is taken from `ad_in[7:0]` and `addr_out[7:0]` from `ad_in[15:8]`, with `addr_out[19:16]` = 0.
- R4: In mode 2, at the falling edge of `ale_in`, `addr_out[11:4]` is taken from `ad_in[7:0]`, `addr_out[19:12]` is set to 0, and `ad_in[15:8]` is ignored.
- R5: In mode 3, at the falling edge of `ale_in`, `addr_out[19:4]` is taken from `ad_in[15:0]`.
- R6: In modes 2 and 3, `addr_out[3:0]` follows the synchronized `a_lo_in` with no `ale_in` pulse. This allows a burst of 16 consecutive low-nibble values under one latched upper address.
- R7: `addr_out[19:4]` changes only on a detected `ale_in` falling edge. Data driven on `ad_in` afterwards has no effect on it.
- R8: `fetch_q` is high when `psen_n_in` is low, `wr_q` when `wr_n_in` is low, and `rd_q` when `rd_n_in` is low (in modes 1 to 3 only). In mode 0, `rd_n_in` has no effect on any output.
- R9: `proto_err` is high while more than one of the counted strobes is active at once.
- R10: `data_phase` is high while `ale_in` is low and at least one counted strobe is active.
- R11: `mode_q` takes `mode_sel` only while the bus is idle, meaning `ale_in` is low and no counted strobe is active. A change made during an active cycle takes effect at the next idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Requested pin layout (0 low-byte, 1 page, 2 byte-wide, 3 word-wide) |
| ad_in | input | 16 | Shared address/data lines |
| a_lo_in | input | 4 | Dedicated low-nibble address lines |
| ale_in | input | 1 | Address latch enable, active high |
| rd_n_in | input | 1 | Read strobe, active low |
| wr_n_in | input | 1 | Write strobe, active low |
| psen_n_in | input | 1 | Program fetch strobe, active low |
| addr_out | output | 20 | Recovered address |
| rd_q | output | 1 | Read qualifier |
| wr_q | output | 1 | Write qualifier |
| fetch_q | output | 1 | Fetch qualifier |
| data_phase | output | 1 | Strobe active after the address phase |
| proto_err | output | 1 | More than one strobe active |
| mode_q | output | 2 | Layout in effect |

## Verification
A wrong captured upper address stays visible on `addr_out` for the whole cycle. It shows up three clocks after the pin edge of `ale_in` and persists until the next latch-enable edge. Any corruption by later data on the shared lines is therefore visible at once. A broken low-nibble path shows within three clocks of a step on `a_lo_in`, in one of two ways: a burst step is not followed, or a non-burst layout starts to follow the pins. A mode register that updates while the bus is busy shows on `mode_q` before the strobe is released. Strobe decoding errors show on the qualifier outputs two clocks after the pin change.

// File: rtl/mab_pkg.sv
package mab_pkg;

  localparam int ADDR_W = 20;
  localparam int AD_W   = 16;
  localparam int NIB_W  = 4;
  localparam int UP_W   = ADDR_W - NIB_W;

  typedef enum logic [1:0] {
    MODE_LOW   = 2'd0,
    MODE_PAGE  = 2'd1,
    MODE_MUX8  = 2'd2,
    MODE_MUX16 = 2'd3
  } mode_e;

  // Full address seen at the latch-enable edge for a given layout.
  function automatic logic [ADDR_W-1:0] capture_addr(
      input mode_e m, input logic [AD_W-1:0] ad, input logic [NIB_W-1:0] alo);
    logic [ADDR_W-1:0] a;
    a = '0;
    unique case (m)
      MODE_LOW:   a = {4'h0, ad[15:8], ad[7:0]};
      MODE_PAGE:  a = {4'h0, ad[7:0], ad[15:8]};
      MODE_MUX8:  a = {8'h00, ad[7:0], alo};
      MODE_MUX16: a = {ad, alo};
      default:    a = '0;
    endcase
    return a;
  endfunction

  // Low nibble tracks the dedicated pins live in these layouts.
  function automatic logic is_burst(input mode_e m);
    return (m == MODE_MUX8) || (m == MODE_MUX16);
  endfunction

  // Whether the read strobe takes part in this layout.
  function automatic logic uses_rd(input mode_e m);
    return m != MODE_LOW;
  endfunction

endpackage

// File: rtl/mab_sync.sv
module mab_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[g] <= RST_VAL;
        end else begin
          if (g == 0) stage[g] <= d;
          else        stage[g] <= stage[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mab_capture.sv
module mab_capture
  import mab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic [AD_W-1:0]   ad_s,
  input  logic [NIB_W-1:0]  alo_s,
  input  mode_e             mode,
  output logic              ale_fall,
  output logic [UP_W-1:0]   up_lat,
  output logic [NIB_W-1:0]  lo_lat
);
  logic              ale_d;
  logic [ADDR_W-1:0] cap_val;

  assign ale_fall = ale_d & ~ale_s;
  assign cap_val  = capture_addr(mode, ad_s, alo_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      up_lat <= '0;
      lo_lat <= '0;
    end else begin
      ale_d <= ale_s;
      if (ale_fall) begin
        up_lat <= cap_val[ADDR_W-1:NIB_W];
        lo_lat <= cap_val[NIB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mab_strobe.sv
module mab_strobe
  import mab_pkg::*;
(
  input  mode_e mode,
  input  logic  ale_s,
  input  logic  rd_n_s,
  input  logic  wr_n_s,
  input  logic  psen_n_s,
  output logic  rd_q,
  output logic  wr_q,
  output logic  fetch_q,
  output logic  any_strobe,
  output logic  multi_strobe,
  output logic  data_phase,
  output logic  bus_busy
);
  logic [1:0] n_active;

  assign rd_q    = ~rd_n_s & uses_rd(mode);
  assign wr_q    = ~wr_n_s;
  assign fetch_q = ~psen_n_s;

  always_comb begin
    n_active = {1'b0, rd_q} + {1'b0, wr_q} + {1'b0, fetch_q};
  end

  assign any_strobe   = n_active != 2'd0;
  assign multi_strobe = n_active > 2'd1;
  assign data_phase   = ~ale_s & any_strobe;
  assign bus_busy     = ale_s | any_strobe;
endmodule

// File: rtl/mab_top.sv
module mab_top
  import mab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic [15:0] ad_in,
  input  logic [3:0]  a_lo_in,
  input  logic        ale_in,
  input  logic        rd_n_in,
  input  logic        wr_n_in,
  input  logic        psen_n_in,
  output logic [19:0] addr_out,
  output logic        rd_q,
  output logic        wr_q,
  output logic        fetch_q,
  output logic        data_phase,
  output logic        proto_err,
  output logic [1:0]  mode_q
);
  localparam int BUS_W = 2 + AD_W + NIB_W + 4;
  localparam logic [BUS_W-1:0] BUS_RST = {{(BUS_W-3){1'b0}}, 3'b111};

  logic [BUS_W-1:0] raw_bus, syn_bus;
  logic [1:0]       mode_sel_s;
  logic [AD_W-1:0]  ad_s;
  logic [NIB_W-1:0] alo_s;
  logic             ale_s, rd_n_s, wr_n_s, psen_n_s;

  assign raw_bus = {mode_sel, ad_in, a_lo_in, ale_in, rd_n_in, wr_n_in, psen_n_in};
  assign {mode_sel_s, ad_s, alo_s, ale_s, rd_n_s, wr_n_s, psen_n_s} = syn_bus;

  mab_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
  );

  mode_e mode_r;
  logic  bus_busy, any_strobe, multi_strobe, ale_fall, burst;
  logic [UP_W-1:0]  up_lat;
  logic [NIB_W-1:0] lo_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_r <= MODE_LOW;
    else if (!bus_busy) mode_r <= mode_e'(mode_sel_s);
  end

  mab_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .ad_s(ad_s), .alo_s(alo_s),
    .mode(mode_r), .ale_fall(ale_fall), .up_lat(up_lat), .lo_lat(lo_lat)
  );

  mab_strobe u_stb (
    .mode(mode_r), .ale_s(ale_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
    .psen_n_s(psen_n_s), .rd_q(rd_q), .wr_q(wr_q), .fetch_q(fetch_q),
    .any_strobe(any_strobe), .multi_strobe(multi_strobe),
    .data_phase(data_phase), .bus_busy(bus_busy)
  );

  assign burst     = is_burst(mode_r);
  assign addr_out  = {up_lat, burst ? alo_s : lo_lat};
  assign proto_err = multi_strobe;
  assign mode_q    = mode_r;
endmodule

// File: rtl/mab_chk.sv
module mab_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ale_fall,
  input logic        bus_busy,
  input logic [3:0]  alo_s,
  input logic [19:0] addr_out,
  input logic        rd_q,
  input logic        wr_q,
  input logic        fetch_q,
  input logic        data_phase,
  input logic        proto_err,
  input logic [1:0]  mode_q
);
  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(addr_out[19:4]));

  // R6
  burst_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] == 1'b1) |-> (addr_out[3:0] == alo_s));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_err |-> $onehot0({rd_q, wr_q, fetch_q}));

  // R10
  data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (rd_q | wr_q | fetch_q));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> $stable(mode_q));

  // R8
  no_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !rd_q);
endmodule

bind mab_top mab_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale_fall(ale_fall), .bus_busy(bus_busy),
  .alo_s(alo_s), .addr_out(addr_out), .rd_q(rd_q), .wr_q(wr_q),
  .fetch_q(fetch_q), .data_phase(data_phase), .proto_err(proto_err),
  .mode_q(mode_q)
);

// File: tb/sim_mab_top.sv
module sim_mab_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] ad_in = '0;
  logic [3:0]  a_lo_in = '0;
  logic        ale_in = 1'b0, rd_n_in = 1'b1, wr_n_in = 1'b1, psen_n_in = 1'b1;
  logic [19:0] addr_out;
  logic        rd_q, wr_q, fetch_q, data_phase, proto_err;
  logic [1:0]  mode_q;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mab_top u0 (.*);

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Expected address per layout, built field by field.
  function automatic logic [19:0] model(input logic [1:0] m, input logic [15:0] ad,
                                        input logic [3:0] lo);
    logic [19:0] r;
    r = 20'h0;
    if (m == 2'd0)      begin r[7:0] = ad[7:0];  r[15:8] = ad[15:8]; end
    else if (m == 2'd1) begin r[7:0] = ad[15:8]; r[15:8] = ad[7:0];  end
    else if (m == 2'd2) begin r[3:0] = lo; r[11:4] = ad[7:0]; end
    else                begin r[3:0] = lo; r[19:4] = ad; end
    return r;
  endfunction

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m;
    wait_clk(4);
  endtask

  task automatic addr_cycle(input logic [15:0] ad, input logic [3:0] lo);
    ad_in = ad; a_lo_in = lo; ale_in = 1'b1;
    wait_clk(4);
    ale_in = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_reset;
    check("R1 addr", addr_out, 20'h0);
    check("R1 flags", {15'h0, rd_q, wr_q, fetch_q, data_phase, proto_err}, 20'h0);
    check("R1 mode", {18'h0, mode_q}, 20'h0);
  endtask

  task automatic t_mode(input logic [1:0] m, input logic [15:0] ad, input logic [3:0] lo,
                        input string req);
    set_mode(m);
    addr_cycle(ad, lo);
    check(req, addr_out, model(m, ad, lo));
    ad_in = ~ad;          // data on shared lines afterwards
    wait_clk(4);
    check("R7 data ignored", addr_out, model(m, ad, lo));
  endtask

  task automatic t_low_no_follow;
    set_mode(2'd0);
    addr_cycle(16'hA5C3, 4'h3);
    a_lo_in = 4'hE;
    wait_clk(4);
    check("R2 no nibble follow", addr_out, 20'h0A5C3);
  endtask

  task automatic t_burst;
    set_mode(2'd3);
    addr_cycle(16'h9B7D, 4'h0);
    for (int i = 0; i < 16; i++) begin
      ad_in = 16'(i * 16'h1111);
      a_lo_in = 4'(i);
      wait_clk(3);
      check("R6 burst step", addr_out, {16'h9B7D, 4'(i)});
    end
    set_mode(2'd2);
    addr_cycle(16'hFF42, 4'h5);
    a_lo_in = 4'hC;
    wait_clk(3);
    check("R6 mux8 nibble", addr_out, 20'h0042C);
  endtask

  task automatic t_strobes;
    set_mode(2'd1);
    rd_n_in = 1'b0;
    wait_clk(3);
    check("R8 rd", {17'h0, rd_q, wr_q, fetch_q}, 20'h4);
    check("R10 data phase", {19'h0, data_phase}, 20'h1);
    wr_n_in = 1'b0;
    wait_clk(3);
    check("R9 double", {19'h0, proto_err}, 20'h1);
    rd_n_in = 1'b1; wr_n_in = 1'b1;
    wait_clk(3);
    check("R9 clear", {19'h0, proto_err}, 20'h0);
    psen_n_in = 1'b0;
    ale_in = 1'b1;
    wait_clk(3);
    check("R8 fetch", {17'h0, rd_q, wr_q, fetch_q}, 20'h1);
    check("R10 ale high", {19'h0, data_phase}, 20'h0);
    ale_in = 1'b0; psen_n_in = 1'b1;
    wait_clk(3);
    set_mode(2'd0);
    rd_n_in = 1'b0; psen_n_in = 1'b0;
    wait_clk(3);
    check("R8 rd ignored mode0", {17'h0, rd_q, wr_q, fetch_q}, 20'h1);
    check("R9 no err mode0", {19'h0, proto_err}, 20'h0);
    psen_n_in = 1'b1;
    wait_clk(3);
    check("R8 rd ignored dp", {18'h0, data_phase, proto_err}, 20'h0);
    rd_n_in = 1'b1;
    wait_clk(3);
  endtask

  task automatic t_mode_busy;
    set_mode(2'd2);
    psen_n_in = 1'b0;
    wait_clk(3);
    mode_sel = 2'd1;
    wait_clk(5);
    check("R11 held busy", {18'h0, mode_q}, 20'h2);
    psen_n_in = 1'b1;
    wait_clk(4);
    check("R11 idle update", {18'h0, mode_q}, 20'h1);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_mode(2'd0, 16'h1234, 4'h7, "R2 low mux");
    t_mode(2'd1, 16'h3CA9, 4'h2, "R3 page");
    t_mode(2'd2, 16'hEE5A, 4'h6, "R4 mux8");
    t_mode(2'd3, 16'hC0DE, 4'hB, "R5 mux16");
    t_low_no_follow();
    t_burst();
    t_strobes();
    t_mode_busy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule